// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the access address for a pipelined synchronous memory controller. A load cycle captures a full external address, the access type (read or write) and the burst order. Each later advance cycle moves only the low burst-index bits of the address, so up to four accesses run from one supplied address. The upper address bits stay constant for the whole burst. The index follows one of two orders, chosen by a mode input: a linear count that wraps, or an order in which the start index is XORed with the beat number.

A load with the chip select inactive ends the current burst. Advance cycles ignore the select and the write input, so a burst keeps the type it had at its load. An advance that arrives while the block is deselected does not start anything, and only a new load restarts activity. A stall input freezes every register. All outputs come from registers and change in the cycle after the edge that sampled the command.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `valid` is 0, `wr_out` is 0 and `addr_out` is all zeros.
- R2: A clock edge with `stall`=0, `load`=1 and `sel`=1 makes `addr_out` equal to `addr_in`, `wr_out` equal to `wr_in` and `valid` equal to 1 from the next cycle on.
- R3: A clock edge with `stall`=0, `load`=1 and `sel`=0 clears `valid` from the next cycle on.
- R4: In linear order (`order`=0 at load), each advance edge (`stall`=0, `load`=0, `valid`=1) sets the two low address bits to the previous value plus one, modulo 4.
- R5: In interleaved order (`order`=1 at load), the two low address bits after the k-th advance equal the start bits XOR k (k modulo 4).
- R6: During an advance, address bits above bit 1 and `wr_out` hold their loaded values, and `sel` and `wr_in` have no effect.
- R7: After four advances the address is back at the loaded address.
- R8: An advance edge while `valid`=0 leaves `valid` at 0.
- R9: An edge with `stall`=1 leaves `addr_out`, `wr_out` and `valid` unchanged, whatever the other inputs are.
- R10: The order is captured at load. Changing `order` during a burst does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | 1 = hold all state for this edge |
| load | input | 1 | 1 = load a new address, 0 = advance the burst |
| addr_in | input | ADDR_W | External start address |
| sel | input | 1 | 1 = all chip enables active (used only on load) |
| wr_in | input | 1 | Access type at load: 1 = write, 0 = read |
| order | input | 1 | Burst order strap: 0 = linear, 1 = interleaved |
| addr_out | output | ADDR_W | Current access address |
| wr_out | output | 1 | Access type held for the burst |
| valid | output | 1 | 1 = an access is active in this cycle |

## Verification
The hardest states to reach from the ports are those in the middle of an interleaved burst that started at an odd index. At the same point the bench changes `sel`, `wr_in` and `order`, so it can check that none of them disturbs the sequence. The stimulus loads start index 01 in interleaved order and then advances with the select off, the opposite write value and the opposite order. It inserts stall edges between advances and runs to the fourth advance, which must land back on the start address. A reference model in the bench computes each expected beat from the requirements and pushes it into a queue.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_DESEL = 2'd2,
        CMD_STEP  = 2'd3
    } cmd_e;

    function automatic cmd_e decode_cmd(input logic stall, input logic load,
                                        input logic sel, input logic active);
        cmd_e c;
        if (stall)        c = CMD_HOLD;
        else if (load)    c = sel ? CMD_LOAD : CMD_DESEL;
        else if (active)  c = CMD_STEP;
        else              c = CMD_HOLD;
        return c;
    endfunction

endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_in,
    input  logic              order_in,
    output logic [ADDR_W-1:0] base_q,
    output logic              wr_q,
    output order_e            ord_q,
    output logic              active_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            wr_q     <= 1'b0;
            ord_q    <= ORD_LINEAR;
            active_q <= 1'b0;
        end else begin
            unique case (cmd)
                CMD_LOAD: begin
                    base_q   <= addr_in;
                    wr_q     <= wr_in;
                    ord_q    <= order_e'(order_in);
                    active_q <= 1'b1;
                end
                CMD_DESEL: active_q <= 1'b0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/burst_beat.sv
module burst_beat
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    output logic [BEAT_W-1:0] beat_q
);

    always_ff @(posedge clk) begin
        if (rst)                   beat_q <= '0;
        else if (cmd == CMD_LOAD)  beat_q <= '0;
        else if (cmd == CMD_STEP)  beat_q <= beat_q + 1'b1;
    end

endmodule

// File: rtl/burst_map.sv
module burst_map
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  order_e            ord,
    output logic [BEAT_W-1:0] low
);

    logic [BEAT_W-1:0] lin_idx;
    logic [BEAT_W-1:0] xor_idx;

    assign lin_idx = start + beat;

    for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
        assign xor_idx[i] = start[i] ^ beat[i];
    end

    assign low = (ord == ORD_XOR) ? xor_idx : lin_idx;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              sel,
    input  logic              wr_in,
    input  logic              order,
    output logic [ADDR_W-1:0] addr_out,
    output logic              wr_out,
    output logic              valid
);

    localparam int HI_W = ADDR_W - BEAT_W;

    cmd_e              cmd;
    logic [ADDR_W-1:0] base_q;
    order_e            ord_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] low;

    assign cmd = decode_cmd(stall, load, sel, valid);

    burst_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .addr_in  (addr_in),
        .wr_in    (wr_in),
        .order_in (order),
        .base_q   (base_q),
        .wr_q     (wr_out),
        .ord_q    (ord_q),
        .active_q (valid)
    );

    burst_beat #(.BEAT_W(BEAT_W)) u_beat (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .beat_q (beat_q)
    );

    burst_map #(.BEAT_W(BEAT_W)) u_map (
        .start (base_q[BEAT_W-1:0]),
        .beat  (beat_q),
        .ord   (ord_q),
        .low   (low)
    );

    assign addr_out = {base_q[ADDR_W-1 -: HI_W], low};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic              load,
    input logic [ADDR_W-1:0] addr_in,
    input logic              sel,
    input logic              wr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              wr_out,
    input logic              valid
);

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !valid);

    p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (!stall && load && sel) |=> (valid && addr_out == $past(addr_in) && wr_out == $past(wr_in)));

    p_desel_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (!stall && load && !sel) |=> !valid);

    p_step_upper_r6: assert property (@(posedge clk) disable iff (rst)
        (!stall && !load && valid) |=> (valid && $stable(wr_out) &&
                                        $stable(addr_out[ADDR_W-1:BEAT_W])));

    p_idle_advance_r8: assert property (@(posedge clk) disable iff (rst)
        (!stall && !load && !valid) |=> !valid);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(addr_out) && $stable(wr_out) && $stable(valid)));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .stall    (stall),
    .load     (load),
    .addr_in  (addr_in),
    .sel      (sel),
    .wr_in    (wr_in),
    .addr_out (addr_out),
    .wr_out   (wr_out),
    .valid    (valid)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stall = 1'b0;
    logic          load = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          sel = 1'b0;
    logic          wr_in = 1'b0;
    logic          order = 1'b0;
    logic [AW-1:0] addr_out;
    logic          wr_out;
    logic          valid;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u0 (
        .clk(clk), .rst(rst), .stall(stall), .load(load), .addr_in(addr_in),
        .sel(sel), .wr_in(wr_in), .order(order),
        .addr_out(addr_out), .wr_out(wr_out), .valid(valid)
    );

    typedef struct {
        logic [AW-1:0] addr;
        logic          wr;
        logic          vld;
        string         req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // reference model state
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_k = 2'd0;
    logic          m_wr = 1'b0;
    logic          m_ilv = 1'b0;
    logic          m_vld = 1'b0;

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] s;
        s = m_base[1:0];
        if (m_ilv) return {m_base[AW-1:2], s ^ m_k};
        else       return {m_base[AW-1:2], 2'(s + m_k)};
    endfunction

    task automatic cyc(input logic st, input logic ld, input logic [AW-1:0] a,
                       input logic sl, input logic w, input logic od, input string tag);
        exp_t e;
        @(negedge clk);
        stall = st; load = ld; addr_in = a; sel = sl; wr_in = w; order = od;
        if (!st) begin
            if (ld && sl) begin
                m_base = a; m_k = 2'd0; m_wr = w; m_ilv = od; m_vld = 1'b1;
            end else if (ld) begin
                m_vld = 1'b0;
            end else if (m_vld) begin
                m_k = m_k + 2'd1;
            end
        end
        e.addr = model_addr(); e.wr = m_wr; e.vld = m_vld; e.req = tag;
        q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (valid !== e.vld || (e.vld && (addr_out !== e.addr || wr_out !== e.wr))) begin
                    n_bad++;
                    $display("FAIL %s: got addr=%h wr=%b valid=%b, expected addr=%h wr=%b valid=%b",
                             e.req, addr_out, wr_out, valid, e.addr, e.wr, e.vld);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        n_cmp++;
        if (valid !== 1'b0 || wr_out !== 1'b0 || addr_out !== '0) begin
            n_bad++;
            $display("FAIL R1: got addr=%h wr=%b valid=%b, expected 0/0/0", addr_out, wr_out, valid);
        end
        @(negedge clk); rst = 1'b0;

        // R8: advance while idle after reset
        cyc(0, 0, 18'h3ffff, 1, 1, 0, "R8");
        // R2 + R4 + R7: linear burst from index 01, read
        cyc(0, 1, 18'h2a5c1, 1, 0, 0, "R2");
        cyc(0, 0, 18'h00000, 1, 1, 0, "R4");
        cyc(0, 0, 18'h00000, 1, 0, 0, "R4");
        cyc(0, 0, 18'h00000, 1, 0, 0, "R4");
        cyc(0, 0, 18'h00000, 1, 0, 0, "R7");
        // R5 + R6 + R10 + R9: interleaved burst from index 01, write
        cyc(0, 1, 18'h15555, 1, 1, 1, "R2");
        cyc(0, 0, 18'h3ffff, 0, 0, 0, "R5");
        cyc(1, 1, 18'h00000, 0, 0, 0, "R9");
        cyc(1, 0, 18'h12345, 1, 0, 1, "R9");
        cyc(0, 0, 18'h00000, 0, 0, 0, "R10");
        cyc(0, 0, 18'h00000, 1, 0, 1, "R6");
        cyc(0, 0, 18'h00000, 0, 1, 0, "R7");
        // interleaved from index 10
        cyc(0, 1, 18'h0fff2, 1, 0, 1, "R2");
        cyc(0, 0, 18'h00000, 1, 1, 1, "R5");
        cyc(0, 0, 18'h00000, 1, 1, 1, "R5");
        cyc(0, 0, 18'h00000, 1, 1, 1, "R5");
        // R3 then R8
        cyc(0, 1, 18'h11111, 0, 1, 0, "R3");
        cyc(0, 0, 18'h22222, 1, 1, 0, "R8");
        cyc(0, 0, 18'h22222, 0, 0, 0, "R8");
        cyc(1, 1, 18'h33333, 1, 1, 0, "R9");
        // linear from index 11 wraps through 00
        cyc(0, 1, 18'h3c003, 1, 1, 0, "R2");
        cyc(0, 0, 18'h00000, 0, 0, 1, "R4");
        cyc(0, 0, 18'h00000, 0, 0, 1, "R4");
        cyc(1, 0, 18'h00000, 1, 0, 0, "R9");
        cyc(0, 0, 18'h00000, 0, 0, 1, "R4");
        cyc(0, 0, 18'h00000, 0, 0, 1, "R7");
        // back-to-back loads
        cyc(0, 1, 18'h00000, 1, 1, 0, "R2");
        cyc(0, 1, 18'h3ffff, 1, 0, 1, "R2");
        cyc(0, 1, 18'h3ffff, 0, 0, 1, "R3");

        @(negedge clk); stall = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule